// File: doc/BRIEF.md
# Partitioned Dispatch Buffer Allocator

This block holds instructions that have been dispatched but not yet issued. Its storage is split into equal partitions, and each partition can be switched into or out of service on its own. A partition that is out of service is powered down and takes no new entries. Each cycle one instruction may be dispatched. It goes into a free entry of an in-service partition, with the tags of its two source operands and a flag for each that says whether that operand is already available. A wakeup port broadcasts one produced tag per cycle, and every waiting operand that matches the tag becomes ready.

For each function unit type the block picks, among the entries whose operands are both ready, the one dispatched earliest. It offers that entry on the issue port of that type whenever the unit reports itself free. An offered entry is treated as issued at the next clock edge and leaves the buffer.

To take a partition out of service, a disable request is made. From then on the partition takes no new entries, and it powers down once its last resident instruction has issued. An enable request returns it to service. Operand values are not stored here.

Top module: `part_dispatch_buffer`

## Requirements
- R1: After reset the buffer is empty, partitions with index below INIT_ON (default 4) are powered and in service, the remaining partitions are powered down, issue_valid is all zero, disp_ready is 1 and disp_slot is 0.
- R2: Entry index = partition index × PART_ENTRIES + position within the partition. A dispatch is accepted when disp_valid and disp_ready are both 1. It fills the lowest-index free entry of an in-service partition, and that index is shown on disp_slot in the same cycle. disp_ready is 0 exactly when no in-service entry is free.
- R3: No entry is allocated in a partition that is powered down or has a pending disable. A dispatch presented while disp_ready is 0 is dropped.
- R4: issue_valid[f] is 1 only when the function unit type f is free and some resident entry of type f has both source operands ready.
- R5: A wakeup with wake_valid=1 marks every resident source operand whose tag equals wake_tag as ready from the next cycle. It also marks a source of the instruction being dispatched in that same cycle.
- R6: When several entries of one function unit type are ready, the one dispatched earliest is offered on that type's issue port.
- R7: After a disable request, a partition stays powered while any entry in it is occupied. part_pwr_en for it drops one cycle after the cycle in which it is first seen empty.
- R8: An enable request for a powered-down partition makes it powered and allocatable from the next cycle.
- R9: An entry offered with issue_valid and fu_free both 1 leaves the buffer at that clock edge and can be allocated again from the next cycle.
- R10: An enable request for a partition with a pending disable cancels the disable and returns the partition to service from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| disp_valid | input | 1 | Dispatch request |
| disp_fu | input | FU_W | Function unit type of the dispatched instruction |
| disp_src0_tag | input | TAG_W | Tag of first source operand |
| disp_src0_rdy | input | 1 | First source already available |
| disp_src1_tag | input | TAG_W | Tag of second source operand |
| disp_src1_rdy | input | 1 | Second source already available |
| disp_dst_tag | input | TAG_W | Destination tag, returned at issue |
| disp_ready | output | 1 | A free in-service entry exists |
| disp_slot | output | IDX_W | Entry chosen for this cycle's dispatch |
| wake_valid | input | 1 | Wakeup broadcast valid |
| wake_tag | input | TAG_W | Tag of the result being produced |
| fu_free | input | NUM_FU | One bit per function unit type, 1 when it can accept an instruction |
| issue_valid | output | NUM_FU | One bit per type, an instruction is issued to it this cycle |
| issue_slot | output | NUM_FU*IDX_W | Entry index issued, one field per type |
| issue_dst | output | NUM_FU*TAG_W | Destination tag issued, one field per type |
| part_on_req | input | NUM_PARTS | Per-partition enable request |
| part_off_req | input | NUM_PARTS | Per-partition disable request |
| part_pwr_en | output | NUM_PARTS | Per-partition power enable |

## Verification
The hardest situation to reach is a partition that is draining while it still holds an entry whose operands are not ready. In that state the partition must stay powered, and it must shut off exactly one cycle after that entry finally issues. The stimulus gets there by parking one unready instruction in partition 0 and then requesting the disable. It next dispatches a second instruction to confirm that allocation has moved to partition 1. Only after that does it wake the parked operand and free its unit, and it then watches the power enable cycle by cycle. A second sequence re-enables a draining partition while every other partition is off, so disp_ready shows whether the cancel took effect.

// File: rtl/pdb_pkg.sv
// Shared types and helpers for the partitioned dispatch buffer.
// Assumes live entries never span more than half the sequence number range.
package pdb_pkg;
    parameter int unsigned SEQ_W = 8;

    typedef enum logic [1:0] {
        PART_OFF   = 2'd0,
        PART_ON    = 2'd1,
        PART_DRAIN = 2'd2
    } part_state_e;

    // Wrap-aware age compare: true when a was dispatched before b.
    function automatic logic seq_older(input logic [SEQ_W-1:0] a, input logic [SEQ_W-1:0] b);
        logic [SEQ_W-1:0] diff;
        diff = a - b;
        return diff[SEQ_W-1];
    endfunction
endpackage

// File: rtl/pdb_part_ctrl.sv
// Service and power state of one partition.
// A disable request moves it to draining; it powers off once empty.
// An enable request restores service from the next cycle.
// Assumes the empty flag reflects the registered occupancy of this partition.
module pdb_part_ctrl
    import pdb_pkg::*;
#(
    parameter bit START_ON = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic on_req,
    input  logic off_req,
    input  logic empty,
    output logic pwr_en,
    output logic alloc_en
);
    part_state_e state_q, state_d;

    // Next-state selection for the partition.
    always_comb begin
        state_d = state_q;
        case (state_q)
            PART_ON:    if (off_req) state_d = PART_DRAIN;
            PART_DRAIN: if (on_req) state_d = PART_ON;
                        else if (empty) state_d = PART_OFF;
            PART_OFF:   if (on_req) state_d = PART_ON;
            default:    state_d = PART_OFF;
        endcase
    end

    // State register with reset to the configured start state.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= START_ON ? PART_ON : PART_OFF;
        else        state_q <= state_d;
    end

    assign pwr_en   = (state_q != PART_OFF);
    assign alloc_en = (state_q == PART_ON);

    // R7
    drain_keeps_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PART_DRAIN && !empty) |=> pwr_en);
    // R7
    off_is_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_en |-> empty);
    // R8
    enable_next_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_en && on_req) |=> alloc_en);
    // R10
    cancel_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PART_DRAIN && on_req) |=> alloc_en);
endmodule

// File: rtl/pdb_first_free.sv
// Finds the lowest-index set bit of a free mask.
// Assumes IDX_W can hold N-1.
module pdb_first_free #(
    parameter int unsigned N     = 64,
    parameter int unsigned IDX_W = 6
) (
    input  logic [N-1:0]     free_mask,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // Scan from the top so the lowest free entry wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (free_mask[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/pdb_oldest_pick.sv
// Picks the candidate entry with the oldest dispatch sequence number.
// Assumes sequence numbers of candidates lie within half the wrap range.
module pdb_oldest_pick
    import pdb_pkg::*;
#(
    parameter int unsigned N     = 64,
    parameter int unsigned IDX_W = 6
) (
    input  logic [N-1:0]       cand,
    input  logic [N*SEQ_W-1:0] seq_flat,
    output logic               found,
    output logic [IDX_W-1:0]   idx
);
    logic [SEQ_W-1:0] best;

    // Linear age reduction across all candidates.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '0;
        for (int i = 0; i < N; i++) begin
            if (cand[i] && (!found || seq_older(seq_flat[i*SEQ_W +: SEQ_W], best))) begin
                found = 1'b1;
                idx   = IDX_W'(i);
                best  = seq_flat[i*SEQ_W +: SEQ_W];
            end
        end
    end
endmodule

// File: rtl/part_dispatch_buffer.sv
// Dispatch buffer built from power-gated partitions.
// Allocates into the lowest free in-service entry, tracks two source ready
// bits per entry via tag wakeup, and issues the oldest ready entry per
// function unit type when that unit is free.
// Assumes one dispatch and one wakeup per cycle; operand data is held elsewhere.
module part_dispatch_buffer
    import pdb_pkg::*;
#(
    parameter int unsigned PART_ENTRIES = 8,
    parameter int unsigned NUM_PARTS    = 8,
    parameter int unsigned INIT_ON      = 4,
    parameter int unsigned TAG_W        = 6,
    parameter int unsigned NUM_FU       = 2,
    localparam int unsigned N           = PART_ENTRIES * NUM_PARTS,
    localparam int unsigned IDX_W       = (N > 1) ? $clog2(N) : 1,
    localparam int unsigned FU_W        = (NUM_FU > 1) ? $clog2(NUM_FU) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    disp_valid,
    input  logic [FU_W-1:0]         disp_fu,
    input  logic [TAG_W-1:0]        disp_src0_tag,
    input  logic                    disp_src0_rdy,
    input  logic [TAG_W-1:0]        disp_src1_tag,
    input  logic                    disp_src1_rdy,
    input  logic [TAG_W-1:0]        disp_dst_tag,
    output logic                    disp_ready,
    output logic [IDX_W-1:0]        disp_slot,
    input  logic                    wake_valid,
    input  logic [TAG_W-1:0]        wake_tag,
    input  logic [NUM_FU-1:0]       fu_free,
    output logic [NUM_FU-1:0]       issue_valid,
    output logic [NUM_FU*IDX_W-1:0] issue_slot,
    output logic [NUM_FU*TAG_W-1:0] issue_dst,
    input  logic [NUM_PARTS-1:0]    part_on_req,
    input  logic [NUM_PARTS-1:0]    part_off_req,
    output logic [NUM_PARTS-1:0]    part_pwr_en
);
    logic [N-1:0]       valid_q;
    logic [N-1:0]       rdy0_q, rdy1_q;
    logic [FU_W-1:0]    fu_q   [N];
    logic [TAG_W-1:0]   tag0_q [N];
    logic [TAG_W-1:0]   tag1_q [N];
    logic [TAG_W-1:0]   dst_q  [N];
    logic [N*SEQ_W-1:0] seq_q;
    logic [SEQ_W-1:0]   seq_ctr;

    logic [NUM_PARTS-1:0] part_empty, part_alloc_en;
    logic [N-1:0]         alloc_mask, pwr_mask, free_mask, entry_rdy, issue_clr;
    logic [IDX_W-1:0]     pick_idx [NUM_FU];
    logic                 disp_fire, src0_hit, src1_hit;

    // Per-partition controllers and their entry masks.
    for (genvar p = 0; p < NUM_PARTS; p++) begin : g_part
        pdb_part_ctrl #(.START_ON(p < INIT_ON)) u_ctrl (
            .clk      (clk),
            .rst_n    (rst_n),
            .on_req   (part_on_req[p]),
            .off_req  (part_off_req[p]),
            .empty    (part_empty[p]),
            .pwr_en   (part_pwr_en[p]),
            .alloc_en (part_alloc_en[p])
        );
        assign part_empty[p] = ~|valid_q[p*PART_ENTRIES +: PART_ENTRIES];
        assign alloc_mask[p*PART_ENTRIES +: PART_ENTRIES] = {PART_ENTRIES{part_alloc_en[p]}};
        assign pwr_mask[p*PART_ENTRIES +: PART_ENTRIES]   = {PART_ENTRIES{part_pwr_en[p]}};
    end

    assign free_mask = ~valid_q & alloc_mask;

    pdb_first_free #(.N(N), .IDX_W(IDX_W)) u_free (
        .free_mask (free_mask),
        .found     (disp_ready),
        .idx       (disp_slot)
    );

    assign disp_fire = disp_valid && disp_ready;
    assign src0_hit  = wake_valid && (wake_tag == disp_src0_tag);
    assign src1_hit  = wake_valid && (wake_tag == disp_src1_tag);
    assign entry_rdy = valid_q & rdy0_q & rdy1_q;

    // One oldest-first selector per function unit type.
    for (genvar f = 0; f < NUM_FU; f++) begin : g_fu
        logic [N-1:0] cand;
        logic         found;

        // Candidates: ready entries of this unit type.
        always_comb begin
            for (int i = 0; i < N; i++) cand[i] = entry_rdy[i] && (fu_q[i] == FU_W'(f));
        end

        pdb_oldest_pick #(.N(N), .IDX_W(IDX_W)) u_pick (
            .cand     (cand),
            .seq_flat (seq_q),
            .found    (found),
            .idx      (pick_idx[f])
        );

        assign issue_valid[f] = found && fu_free[f];
        assign issue_slot[f*IDX_W +: IDX_W] = pick_idx[f];
        assign issue_dst[f*TAG_W +: TAG_W]  = dst_q[pick_idx[f]];

        // R4
        issue_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
            issue_valid[f] |-> (rdy0_q[pick_idx[f]] && rdy1_q[pick_idx[f]] && fu_q[pick_idx[f]] == FU_W'(f)));
        // R9
        issue_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
            issue_valid[f] |=> !valid_q[$past(pick_idx[f])]);
    end

    // Entries leaving this cycle through any issue port.
    always_comb begin
        issue_clr = '0;
        for (int f = 0; f < NUM_FU; f++) begin
            if (issue_valid[f]) issue_clr[pick_idx[f]] = 1'b1;
        end
    end

    // Occupancy, ready bits and dispatch sequence counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            rdy0_q  <= '0;
            rdy1_q  <= '0;
            seq_ctr <= '0;
        end else begin
            if (disp_fire) seq_ctr <= seq_ctr + 1'b1;
            for (int i = 0; i < N; i++) begin
                if (disp_fire && disp_slot == IDX_W'(i)) begin
                    valid_q[i] <= 1'b1;
                    rdy0_q[i]  <= disp_src0_rdy || src0_hit;
                    rdy1_q[i]  <= disp_src1_rdy || src1_hit;
                end else begin
                    if (issue_clr[i]) valid_q[i] <= 1'b0;
                    if (wake_valid && wake_tag == tag0_q[i]) rdy0_q[i] <= 1'b1;
                    if (wake_valid && wake_tag == tag1_q[i]) rdy1_q[i] <= 1'b1;
                end
            end
        end
    end

    // Payload capture at dispatch; no reset needed.
    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (disp_fire && disp_slot == IDX_W'(i)) begin
                fu_q[i]   <= disp_fu;
                tag0_q[i] <= disp_src0_tag;
                tag1_q[i] <= disp_src1_tag;
                dst_q[i]  <= disp_dst_tag;
                seq_q[i*SEQ_W +: SEQ_W] <= seq_ctr;
            end
        end
    end

    // R2
    alloc_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_fire |-> !valid_q[disp_slot]);
    // R2
    alloc_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_fire |=> valid_q[$past(disp_slot)]);
    // R3
    alloc_powered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_fire |-> pwr_mask[disp_slot]);
endmodule

// File: tb/tb_part_dispatch_buffer.sv
module tb_part_dispatch_buffer;
    localparam int IW = 6;
    localparam int TW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic disp_valid = 1'b0;
    logic [0:0] disp_fu = '0;
    logic [TW-1:0] disp_src0_tag = '0, disp_src1_tag = '0, disp_dst_tag = '0;
    logic disp_src0_rdy = 1'b0, disp_src1_rdy = 1'b0;
    logic disp_ready;
    logic [IW-1:0] disp_slot;
    logic wake_valid = 1'b0;
    logic [TW-1:0] wake_tag = '0;
    logic [1:0] fu_free = '0;
    logic [1:0] issue_valid;
    logic [2*IW-1:0] issue_slot;
    logic [2*TW-1:0] issue_dst;
    logic [7:0] part_on_req = '0, part_off_req = '0;
    logic [7:0] part_pwr_en;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    part_dispatch_buffer dut (
        .clk(clk), .rst_n(rst_n),
        .disp_valid(disp_valid), .disp_fu(disp_fu),
        .disp_src0_tag(disp_src0_tag), .disp_src0_rdy(disp_src0_rdy),
        .disp_src1_tag(disp_src1_tag), .disp_src1_rdy(disp_src1_rdy),
        .disp_dst_tag(disp_dst_tag), .disp_ready(disp_ready), .disp_slot(disp_slot),
        .wake_valid(wake_valid), .wake_tag(wake_tag),
        .fu_free(fu_free), .issue_valid(issue_valid),
        .issue_slot(issue_slot), .issue_dst(issue_dst),
        .part_on_req(part_on_req), .part_off_req(part_off_req), .part_pwr_en(part_pwr_en)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; disp_valid = 1'b0; wake_valid = 1'b0; fu_free = '0;
        part_on_req = '0; part_off_req = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic dispatch(input int fu, input int t0, input bit r0, input int t1, input bit r1,
                            input int dst, input int exp_slot, input string req);
        @(negedge clk);
        disp_valid = 1'b1; disp_fu = 1'(fu);
        disp_src0_tag = TW'(t0); disp_src0_rdy = r0;
        disp_src1_tag = TW'(t1); disp_src1_rdy = r1;
        disp_dst_tag = TW'(dst);
        #1;
        chk(disp_ready == 1'b1, req, "disp_ready", int'(disp_ready), 1);
        chk(disp_slot == IW'(exp_slot), req, "disp_slot", int'(disp_slot), exp_slot);
        @(posedge clk); #1;
        disp_valid = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        #1;
        chk(part_pwr_en == 8'h0F, "R1", "pwr_en", int'(part_pwr_en), 15);
        chk(disp_ready == 1'b1, "R1", "disp_ready", int'(disp_ready), 1);
        chk(disp_slot == '0, "R1", "disp_slot", int'(disp_slot), 0);
        chk(issue_valid == '0, "R1", "issue_valid", int'(issue_valid), 0);
    endtask

    task automatic t_fill();
        int issued = 0;
        do_reset();
        for (int i = 0; i < 32; i++) dispatch(0, 5, 1'b0, 6, 1'b1, i, i, "R2");
        @(negedge clk); #1;
        chk(disp_ready == 1'b0, "R3", "disp_ready when full", int'(disp_ready), 0);
        chk(part_pwr_en == 8'h0F, "R3", "pwr_en", int'(part_pwr_en), 15);
        disp_valid = 1'b1; disp_dst_tag = 6'd60;
        @(posedge clk); #1;
        disp_valid = 1'b0;
        @(negedge clk);
        wake_valid = 1'b1; wake_tag = 6'd5; fu_free = 2'b01;
        @(posedge clk); #1;
        wake_valid = 1'b0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk); #1;
            if (issue_valid[0]) issued++;
            @(posedge clk);
        end
        chk(issued == 32, "R3", "entries drained (dropped dispatch absent)", issued, 32);
        fu_free = '0;
    endtask

    task automatic t_wake_issue();
        do_reset();
        dispatch(1, 7, 1'b0, 8, 1'b0, 40, 0, "R2");
        @(negedge clk);
        disp_valid = 1'b1; disp_fu = 1'b0;
        disp_src0_tag = 6'd9; disp_src0_rdy = 1'b0;
        disp_src1_tag = 6'd3; disp_src1_rdy = 1'b1; disp_dst_tag = 6'd41;
        wake_valid = 1'b1; wake_tag = 6'd9;
        #1;
        chk(disp_slot == 6'd1, "R2", "second slot", int'(disp_slot), 1);
        @(posedge clk); #1;
        disp_valid = 1'b0; wake_valid = 1'b0;
        @(negedge clk);
        fu_free = 2'b10; wake_valid = 1'b1; wake_tag = 6'd7;
        #1;
        chk(issue_valid == 2'b00, "R4", "ready entry but unit busy", int'(issue_valid), 0);
        @(posedge clk); #1;
        wake_valid = 1'b0;
        @(negedge clk); #1;
        chk(issue_valid == 2'b00, "R5", "one source still pending", int'(issue_valid), 0);
        wake_valid = 1'b1; wake_tag = 6'd8;
        @(posedge clk); #1;
        wake_valid = 1'b0;
        @(negedge clk); #1;
        chk(issue_valid == 2'b10, "R5", "issue after both wakeups", int'(issue_valid), 2);
        chk(issue_dst[TW +: TW] == 6'd40, "R4", "unit1 dst", int'(issue_dst[TW +: TW]), 40);
        chk(issue_slot[IW +: IW] == 6'd0, "R4", "unit1 slot", int'(issue_slot[IW +: IW]), 0);
        @(posedge clk);
        @(negedge clk); #1;
        chk(issue_valid == 2'b00, "R9", "issued entry gone", int'(issue_valid), 0);
        fu_free = 2'b01;
        #1;
        chk(issue_valid == 2'b01, "R5", "same-cycle wakeup at dispatch", int'(issue_valid), 1);
        chk(issue_dst[0 +: TW] == 6'd41, "R5", "unit0 dst", int'(issue_dst[0 +: TW]), 41);
        @(posedge clk);
        @(negedge clk); #1;
        chk(issue_valid == 2'b00, "R9", "buffer empty", int'(issue_valid), 0);
        fu_free = '0;
    endtask

    task automatic t_age();
        int exp_order[4] = '{1, 2, 3, 0};
        int exp_dst[4] = '{11, 12, 13, 14};
        do_reset();
        for (int i = 0; i < 4; i++) dispatch(0, 1, 1'b1, 2, 1'b1, 10 + i, i, "R2");
        @(negedge clk);
        fu_free = 2'b01;
        #1;
        chk(issue_slot[0 +: IW] == 6'd0, "R6", "first issue slot", int'(issue_slot[0 +: IW]), 0);
        @(posedge clk); #1;
        fu_free = '0;
        dispatch(0, 1, 1'b1, 2, 1'b1, 14, 0, "R9");
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            fu_free = 2'b01;
            #1;
            chk(issue_valid[0] == 1'b1, "R6", "issue valid", int'(issue_valid[0]), 1);
            chk(issue_slot[0 +: IW] == IW'(exp_order[k]), "R6", "age order slot",
                int'(issue_slot[0 +: IW]), exp_order[k]);
            chk(issue_dst[0 +: TW] == TW'(exp_dst[k]), "R6", "age order dst",
                int'(issue_dst[0 +: TW]), exp_dst[k]);
            @(posedge clk);
        end
        @(negedge clk); #1;
        chk(issue_valid == 2'b00, "R9", "all issued", int'(issue_valid), 0);
        fu_free = '0;
    endtask

    task automatic t_drain();
        do_reset();
        dispatch(0, 20, 1'b0, 0, 1'b1, 50, 0, "R2");
        @(negedge clk);
        part_off_req = 8'h01;
        @(posedge clk); #1;
        part_off_req = '0;
        dispatch(1, 21, 1'b0, 0, 1'b1, 51, 8, "R3");
        @(negedge clk); #1;
        chk(part_pwr_en[0] == 1'b1, "R7", "occupied draining partition powered", int'(part_pwr_en[0]), 1);
        wake_valid = 1'b1; wake_tag = 6'd20; fu_free = 2'b01;
        @(posedge clk); #1;
        wake_valid = 1'b0;
        @(negedge clk); #1;
        chk(issue_valid == 2'b01, "R4", "parked entry issues", int'(issue_valid), 1);
        chk(issue_slot[0 +: IW] == 6'd0, "R4", "parked slot", int'(issue_slot[0 +: IW]), 0);
        @(posedge clk);
        @(negedge clk); #1;
        chk(part_pwr_en[0] == 1'b1, "R7", "still powered first empty cycle", int'(part_pwr_en[0]), 1);
        @(posedge clk);
        @(negedge clk); #1;
        chk(part_pwr_en[0] == 1'b0, "R7", "powered down after empty", int'(part_pwr_en[0]), 0);
        fu_free = '0;
        dispatch(0, 1, 1'b1, 1, 1'b1, 52, 9, "R3");
    endtask

    task automatic t_enable();
        do_reset();
        @(negedge clk);
        part_off_req = 8'h0F; part_on_req = 8'h10;
        @(posedge clk); #1;
        part_off_req = '0; part_on_req = '0;
        @(negedge clk); #1;
        chk(part_pwr_en == 8'h1F, "R8", "pwr_en after enable", int'(part_pwr_en), 31);
        chk(disp_ready == 1'b1, "R8", "disp_ready", int'(disp_ready), 1);
        chk(disp_slot == 6'd32, "R8", "first slot of enabled partition", int'(disp_slot), 32);
        @(posedge clk);
        @(negedge clk); #1;
        chk(part_pwr_en == 8'h10, "R7", "empty partitions off", int'(part_pwr_en), 16);
        dispatch(0, 30, 1'b0, 0, 1'b1, 55, 32, "R8");
        @(negedge clk);
        part_off_req = 8'h10;
        @(posedge clk); #1;
        part_off_req = '0;
        @(negedge clk); #1;
        chk(disp_ready == 1'b0, "R3", "draining partition not allocatable", int'(disp_ready), 0);
        chk(part_pwr_en[4] == 1'b1, "R7", "draining partition powered", int'(part_pwr_en[4]), 1);
        part_on_req = 8'h10;
        @(posedge clk); #1;
        part_on_req = '0;
        @(negedge clk); #1;
        chk(disp_ready == 1'b1, "R10", "cancelled disable", int'(disp_ready), 1);
        chk(disp_slot == 6'd33, "R10", "next slot", int'(disp_slot), 33);
        chk(part_pwr_en == 8'h10, "R10", "pwr_en", int'(part_pwr_en), 16);
    endtask

    initial begin
        t_reset();
        t_fill();
        t_wake_issue();
        t_age();
        t_drain();
        t_enable();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: all requirements, actual 0 expected 1 (run completed)");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule